// File: doc/BRIEF.md
# Iterative Greatest Common Divisor Engine

This block finds the greatest common divisor of two unsigned numbers by repeating one of two steps, one step per clock cycle. When the first working value is smaller than the second, the two are exchanged. Otherwise, if the second is non-zero, the second is subtracted from the first. Once the first is no longer smaller and the second is zero, the first working value holds the answer.

Two registers hold the working values. Each register has a load enable and an input selector. A comparator and a zero detector report their results to a three-state controller, which drives the enables and selectors.

The block accepts one request at a time. In the input-wait state it raises `in_idle`, and an operand pair is captured on any clock edge where `in_avail` is also high. While computing, it ignores its inputs. When the result is ready it raises `res_ready` and holds `res_value` until `res_taken` is seen on a clock edge.

Top module: `gcd_engine`

## Requirements
- R1: A synchronous active-high `reset` puts the block in the input-wait state: `in_idle` is high and `res_ready` is low on the first edge after reset is released.
- R2: `in_idle` is high only in the input-wait state. On a clock edge where `in_idle` and `in_avail` are both high, `opa` and `opb` are captured, and `in_idle` is low from the next cycle.
- R3: During computation, when the first working value is less than the second, the two values are swapped in one cycle. Operand pairs with `opa < opb` give the correct divisor.
- R4: During computation, when the first value is not less than the second and the second is non-zero, the first value is replaced by their difference. Pairs with `opa >= opb` give the correct divisor, even when this takes many thousands of steps.
- R5: Computation ends when the first value is not less than the second and the second is zero. `res_ready` then rises and `res_value` equals the greatest common divisor of the captured operands.
- R6: While `res_ready` is high and `res_taken` is low, `res_ready` stays high and `res_value` stays unchanged. After an edge with `res_taken` high, `res_ready` is low and `in_idle` is high.
- R7: If one operand is zero, the result is the other operand. If both are zero, the result is zero. Equal operands give that value.
- R8: While computing, changes on `opa`, `opb` and `in_avail` have no effect on the result.
- R9: `in_idle` and `res_ready` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| reset | input | 1 | Synchronous reset, active high |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| in_avail | input | 1 | An operand pair is offered |
| in_idle | output | 1 | Block is waiting for operands |
| res_value | output | WIDTH | Computed divisor |
| res_ready | output | 1 | Result is valid and waiting |
| res_taken | input | 1 | Consumer has taken the result |

## Verification
Assertions check on every cycle that the two handshake flags are never high together, that an accepted request leaves the idle state, that a waiting result stays fixed until it is taken, and that each compute step either swaps or subtracts correctly. Only the bench scenarios show that the final values are the true divisors. These scenarios cover pairs that need swaps, long subtraction runs, zero operands, equal operands, and operand changes made while the block is computing. Each result is compared with a reference value computed by the bench.

// File: rtl/gcd_engine.sv
module gcd_engine #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             reset,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             in_avail,
  output logic             in_idle,
  output logic [WIDTH-1:0] res_value,
  output logic             res_ready,
  input  logic             res_taken
);

  typedef enum logic [1:0] {S_LOAD, S_RUN, S_HOLD} state_t;
  typedef enum logic [1:0] {A_NEW, A_FROM_B, A_DIFF} a_sel_t;
  typedef enum logic       {B_NEW, B_FROM_A} b_sel_t;

  state_t           state, state_n;
  a_sel_t           a_sel;
  b_sel_t           b_sel;
  logic             a_en, b_en;
  logic [WIDTH-1:0] a_q, b_q, a_d, b_d, diff;
  logic             a_lt_b, b_zero;

  assign diff   = a_q - b_q;
  assign a_lt_b = a_q < b_q;
  assign b_zero = (b_q == '0);

  always_comb begin
    case (a_sel)
      A_NEW:    a_d = opa;
      A_FROM_B: a_d = b_q;
      default:  a_d = diff;
    endcase
    b_d = (b_sel == B_NEW) ? opb : a_q;
  end

  always_ff @(posedge clk) begin
    if (a_en) a_q <= a_d;
    if (b_en) b_q <= b_d;
  end

  always_comb begin
    state_n = state;
    a_sel   = A_NEW;
    b_sel   = B_NEW;
    a_en    = 1'b0;
    b_en    = 1'b0;
    case (state)
      S_LOAD: if (in_avail) begin
        a_en    = 1'b1;
        b_en    = 1'b1;
        state_n = S_RUN;
      end
      S_RUN: begin
        if (a_lt_b) begin
          a_sel = A_FROM_B;
          b_sel = B_FROM_A;
          a_en  = 1'b1;
          b_en  = 1'b1;
        end else if (!b_zero) begin
          a_sel = A_DIFF;
          a_en  = 1'b1;
        end else begin
          state_n = S_HOLD;
        end
      end
      S_HOLD: if (res_taken) state_n = S_LOAD;
      default: state_n = S_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (reset) state <= S_LOAD;
    else       state <= state_n;
  end

  assign in_idle   = (state == S_LOAD);
  assign res_ready = (state == S_HOLD);
  assign res_value = a_q;

  a_r9_exclusive: assert property (@(posedge clk) disable iff (reset)
    !(in_idle && res_ready));

  a_r2_accept: assert property (@(posedge clk) disable iff (reset)
    in_idle && in_avail |=> !in_idle && !res_ready);

  a_r6_hold: assert property (@(posedge clk) disable iff (reset)
    res_ready && !res_taken |=> res_ready && $stable(res_value));

  a_r6_release: assert property (@(posedge clk) disable iff (reset)
    res_ready && res_taken |=> in_idle);

  a_r3_swap: assert property (@(posedge clk) disable iff (reset)
    !in_idle && !res_ready && a_lt_b |=> a_q == $past(b_q) && b_q == $past(a_q));

  a_r4_subtract: assert property (@(posedge clk) disable iff (reset)
    !in_idle && !res_ready && !a_lt_b && !b_zero |=>
      a_q + $past(b_q) == $past(a_q) && $stable(b_q));

  a_r5_finish: assert property (@(posedge clk) disable iff (reset)
    $rose(res_ready) |-> b_zero);

endmodule

// File: tb/gcd_engine_test.sv
module gcd_engine_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         reset = 1'b1;
  logic [W-1:0] opa = '0, opb = '0;
  logic         in_avail = 1'b0, res_taken = 1'b0;
  logic         in_idle, res_ready;
  logic [W-1:0] res_value;
  int           checks = 0, errors = 0, cycles = 0;
  bit           done = 1'b0;

  gcd_engine #(.WIDTH(W)) uut (
    .clk(clk), .reset(reset), .opa(opa), .opb(opb), .in_avail(in_avail),
    .in_idle(in_idle), .res_value(res_value), .res_ready(res_ready),
    .res_taken(res_taken)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<190000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] t;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!res_ready && n < 70000) begin
      @(negedge clk);
      n++;
    end
    check(res_ready, req, res_ready, 1);
  endtask

  task automatic take_result(input string req);
    res_taken = 1'b1;
    @(negedge clk);
    res_taken = 1'b0;
    check(in_idle && !res_ready, req, {in_idle, res_ready}, 2);
  endtask

  task automatic run_pair(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    logic [W-1:0] exp;
    exp = ref_gcd(x, y);
    @(negedge clk);
    check(in_idle, {req, "/R2 idle"}, in_idle, 1);
    opa = x; opb = y; in_avail = 1'b1;
    @(negedge clk);
    in_avail = 1'b0;
    check(!in_idle, {req, "/R2 accept"}, in_idle, 0);
    wait_ready(req);
    check(res_value == exp, req, res_value, exp);
    take_result({req, "/R6"});
  endtask

  task automatic test_reset;
    @(negedge clk);
    @(negedge clk);
    reset = 1'b0;
    @(negedge clk);
    check(in_idle, "R1 idle", in_idle, 1);
    check(!res_ready, "R1 ready", res_ready, 0);
  endtask

  task automatic test_hold;
    logic [W-1:0] first;
    @(negedge clk);
    opa = 16'd84; opb = 16'd36; in_avail = 1'b1;
    @(negedge clk);
    in_avail = 1'b0;
    wait_ready("R5 hold");
    first = res_value;
    for (int k = 0; k < 5; k++) begin
      opa = 16'd7 + 16'(k); opb = 16'd3; in_avail = 1'b1;
      @(negedge clk);
      check(res_ready && res_value == first, "R6 hold", res_value, first);
      check(!in_idle, "R9 exclusive", in_idle, 0);
    end
    in_avail = 1'b0;
    check(first == 16'd12, "R5 value", first, 12);
    take_result("R6 release");
  endtask

  task automatic test_busy_ignore;
    @(negedge clk);
    opa = 16'd1000; opb = 16'd3; in_avail = 1'b1;
    @(negedge clk);
    opa = 16'd40; opb = 16'd30;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_avail = ~in_avail;
    end
    in_avail = 1'b0;
    opa = 16'd9; opb = 16'd6;
    wait_ready("R8 busy");
    check(res_value == 16'd1, "R8 inputs ignored", res_value, 1);
    take_result("R8 release");
  endtask

  initial begin
    test_reset();
    run_pair(16'd12, 16'd18, "R3 swap");
    run_pair(16'd7, 16'd91, "R3 swap");
    run_pair(16'd48, 16'd18, "R4 subtract");
    run_pair(16'd65535, 16'd1, "R4 long run");
    run_pair(16'd0, 16'd25, "R7 a zero");
    run_pair(16'd33, 16'd0, "R7 b zero");
    run_pair(16'd0, 16'd0, "R7 both zero");
    run_pair(16'd77, 16'd77, "R7 equal");
    run_pair(16'd40320, 16'd3628, "R5 general");
    test_hold();
    test_busy_ignore();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule